// File: doc/BRIEF.md
# Degradable Four-Lane Link Striper

This block spreads a stream of link words over four physical lanes of equal rate and gathers them back into one stream on the receive side. Each lane carries at most one word every four cycles, so four working lanes give the full rate of one word per cycle. When the health vector marks a lane as bad, the block keeps the link up on the three lanes that remain, at three quarters of the full rate. It returns to all four lanes by itself once the lane is marked good again.

A change of lane set is applied only at a group boundary. The transmit side finishes the current round of lanes and stops taking input. The block waits until no word is in flight on the lanes and the receive side has emptied its lane slots. It then switches both sides to the new set in the same cycle. If fewer than three lanes are healthy, the link is declared down and no input is accepted. Lane training, deskew and fault detection are outside the block; faults arrive as the health vector.

Top module: `lane_striper`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `link_up`, `lane_mask` and `in_ready` are all 0. After that, a healthy lane set is brought into use without any other stimulus.
- R2: Each accepted word is sent on exactly one lane. Bit i of `lane_tx_valid` is lane i, and lane i's word sits in `lane_tx_data[i*W +: W]`. Successive words use the lanes set in `lane_mask` in rising index order, wrapping from the highest set lane back to the lowest.
- R3: A lane takes at most one word in any four cycles. With a steady input, four active lanes accept 40 words in any 40 cycles, and three active lanes accept 30.
- R4: A lane whose bit in `lane_mask` is 0 never raises its `lane_tx_valid` bit.
- R5: With each lane's output looped back to its input, `out_data` gives every accepted word exactly once and in acceptance order. This holds across every change of lane set.
- R6: `lane_mask` changes only in a cycle where the previous cycle had no `lane_tx_valid` bit set. Input is stalled while a change is waiting, and no word is lost by the change.
- R7: If fewer than three bits of `lane_healthy` are 1, then `lane_mask` becomes 0, `link_up` goes to 0 and `in_ready` stays 0.
- R8: If three or four bits of `lane_healthy` are 1, then `lane_mask` becomes equal to `lane_healthy` and `link_up` becomes 1. Going back to four healthy lanes restores the full rate of R3 automatically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_data | input | W | Input word |
| in_ready | output | 1 | Block takes the input word this cycle |
| lane_tx_valid | output | 4 | Per-lane transmit strobe |
| lane_tx_data | output | 4*W | Per-lane transmit words, lane i at bits i*W |
| lane_rx_valid | input | 4 | Per-lane receive strobe |
| lane_rx_data | input | 4*W | Per-lane received words, lane i at bits i*W |
| lane_healthy | input | 4 | Lane i usable when bit i is 1 |
| out_valid | output | 1 | Reassembled word present |
| out_data | output | W | Reassembled word |
| link_up | output | 1 | At least three lanes in use |
| lane_mask | output | 4 | Lane set now in use |

## Verification
If the transmit and receive lane pointers get out of step, the next word comes out of `out_data` out of order, or the output stalls for good. This shows within two cycles of the word that follows. If the switch point is wrong, a lane strobe appears in the cycle before `lane_mask` changes, or the output queue loses a word across the change. Either one is visible at the ports in the cycle of the change or at the final drain. A faulty rate limit or link-down gating shows up as the wrong count of accepted words over a forty-cycle window, or as `in_ready` rising while `link_up` is 0.

// File: rtl/striper_pkg.sv
package striper_pkg;
  localparam int LANES     = 4;
  localparam int MIN_LANES = 3;
  localparam int LW        = $clog2(LANES);

  typedef logic [LANES-1:0] lane_mask_t;
  typedef logic [LW-1:0]    lane_idx_t;

  // number of lanes set in a mask
  function automatic int unsigned lane_count(lane_mask_t m);
    int unsigned n = 0;
    for (int i = 0; i < LANES; i++) n += int'(m[i]);
    return n;
  endfunction

  // lowest set lane, 0 for an empty mask
  function automatic lane_idx_t first_lane(lane_mask_t m);
    lane_idx_t r = '0;
    for (int i = LANES - 1; i >= 0; i--) if (m[i]) r = lane_idx_t'(i);
    return r;
  endfunction

  // next set lane above cur, wrapping to the lowest
  function automatic lane_idx_t next_lane(lane_mask_t m, lane_idx_t cur);
    lane_idx_t r = first_lane(m);
    logic      hit = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (!hit && i > int'(cur) && m[i]) begin
        r   = lane_idx_t'(i);
        hit = 1'b1;
      end
    return r;
  endfunction

  // lane set that may be used for a given health vector
  function automatic lane_mask_t usable_set(lane_mask_t h);
    return (lane_count(h) >= MIN_LANES) ? h : '0;
  endfunction
endpackage

// File: rtl/stripe_ctrl.sv
module stripe_ctrl
  import striper_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  lane_mask_t lane_healthy,
  input  logic       group_start,
  input  logic       tx_idle,
  input  logic       rx_drained,
  output lane_mask_t lane_mask,
  output logic       hold_tx,
  output logic       link_up
);
  localparam int CW = $clog2(SETTLE + 1);

  lane_mask_t    target;
  logic          pending, hold_q, drained, commit;
  logic [CW-1:0] settle_cnt;

  assign target  = usable_set(lane_healthy);
  assign pending = (target != lane_mask);
  assign hold_tx = pending && (group_start || hold_q);
  assign drained = hold_q && tx_idle && rx_drained;
  assign commit  = drained && (settle_cnt == CW'(SETTLE - 1));
  assign link_up = (lane_mask != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_mask  <= '0;
      hold_q     <= 1'b0;
      settle_cnt <= '0;
    end else begin
      hold_q     <= hold_tx && !commit;
      settle_cnt <= (drained && !commit) ? settle_cnt + 1'b1 : '0;
      if (commit) lane_mask <= target;
    end
  end

  // R7
  width_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mask == '0) || (lane_count(lane_mask) >= MIN_LANES));
  // R6
  quiet_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mask != $past(lane_mask)) |-> $past(tx_idle));
endmodule

// File: rtl/stripe_tx.sv
module stripe_tx
  import striper_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [W-1:0]       in_data,
  output logic               in_ready,
  input  lane_mask_t         lane_mask,
  input  logic               hold_tx,
  output lane_mask_t         lane_tx_valid,
  output logic [LANES*W-1:0] lane_tx_data,
  output logic               group_start,
  output logic               tx_idle
);
  localparam int BW = (LW < 1) ? 1 : LW;

  lane_idx_t  ptr;
  lane_mask_t mask_q, busy;
  logic       take;

  assign group_start = (ptr == first_lane(lane_mask));
  assign in_ready    = lane_mask[ptr] && !busy[ptr] && !hold_tx && (lane_mask == mask_q);
  assign take        = in_valid && in_ready;
  assign tx_idle     = (lane_tx_valid == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      mask_q <= '0;
    end else if (lane_mask != mask_q) begin
      mask_q <= lane_mask;
      ptr    <= first_lane(lane_mask);
    end else if (take) begin
      ptr <= next_lane(lane_mask, ptr);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BW-1:0] pace;
    logic          v_q;
    logic [W-1:0]  d_q;
    logic          hit;
    assign hit = take && (ptr == lane_idx_t'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pace <= '0;
        v_q  <= 1'b0;
        d_q  <= '0;
      end else begin
        v_q <= hit;
        if (hit) begin
          pace <= BW'(LANES - 1);
          d_q  <= in_data;
        end else if (pace != '0) begin
          pace <= pace - 1'b1;
        end
      end
    end
    assign busy[g]              = (pace != '0);
    assign lane_tx_valid[g]     = v_q;
    assign lane_tx_data[g*W +: W] = d_q;
  end

  // R2
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_tx_valid));
  // R4
  live_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_tx_valid & ~lane_mask) == '0);
endmodule

// File: rtl/stripe_rx.sv
module stripe_rx
  import striper_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  lane_mask_t         lane_mask,
  input  lane_mask_t         lane_rx_valid,
  input  logic [LANES*W-1:0] lane_rx_data,
  output logic               out_valid,
  output logic [W-1:0]       out_data,
  output logic               rx_drained
);
  lane_mask_t   slot_v, mask_q;
  logic [W-1:0] slot_d [LANES];
  lane_idx_t    want;
  logic         consume;

  assign consume    = slot_v[want] && (lane_mask == mask_q);
  assign rx_drained = (slot_v == '0) && (lane_rx_valid == '0) && (want == first_lane(lane_mask));

  for (genvar g = 0; g < LANES; g++) begin : g_slot
    logic         v_q;
    logic [W-1:0] d_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (lane_rx_valid[g]) begin
        v_q <= 1'b1;
        d_q <= lane_rx_data[g*W +: W];
      end else if (consume && want == lane_idx_t'(g)) begin
        v_q <= 1'b0;
      end
    end
    assign slot_v[g] = v_q;
    assign slot_d[g] = d_q;

    // R5
    slot_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(v_q && lane_rx_valid[g] && !(consume && want == lane_idx_t'(g))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      want      <= '0;
      mask_q    <= '0;
    end else begin
      out_valid <= consume;
      if (consume) out_data <= slot_d[want];
      if (lane_mask != mask_q) begin
        mask_q <= lane_mask;
        want   <= first_lane(lane_mask);
      end else if (consume) begin
        want <= next_lane(lane_mask, want);
      end
    end
  end
endmodule

// File: rtl/lane_striper.sv
module lane_striper
  import striper_pkg::*;
#(
  parameter int W      = 16,
  parameter int SETTLE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [W-1:0]       in_data,
  output logic               in_ready,
  output logic [LANES-1:0]   lane_tx_valid,
  output logic [LANES*W-1:0] lane_tx_data,
  input  logic [LANES-1:0]   lane_rx_valid,
  input  logic [LANES*W-1:0] lane_rx_data,
  input  logic [LANES-1:0]   lane_healthy,
  output logic               out_valid,
  output logic [W-1:0]       out_data,
  output logic               link_up,
  output logic [LANES-1:0]   lane_mask
);
  logic hold_tx, group_start, tx_idle, rx_drained;

  stripe_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lane_healthy(lane_healthy),
    .group_start(group_start), .tx_idle(tx_idle), .rx_drained(rx_drained),
    .lane_mask(lane_mask), .hold_tx(hold_tx), .link_up(link_up)
  );

  stripe_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .lane_mask(lane_mask), .hold_tx(hold_tx),
    .lane_tx_valid(lane_tx_valid), .lane_tx_data(lane_tx_data),
    .group_start(group_start), .tx_idle(tx_idle)
  );

  stripe_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .lane_mask(lane_mask),
    .lane_rx_valid(lane_rx_valid), .lane_rx_data(lane_rx_data),
    .out_valid(out_valid), .out_data(out_data), .rx_drained(rx_drained)
  );

  // R7
  ready_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> link_up);
endmodule

// File: tb/test_lane_striper.sv
module test_lane_striper;
  localparam int W = 16;
  localparam int L = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [W-1:0]   in_data = 16'h0100;
  logic           in_ready;
  logic [L-1:0]   lane_tx_valid, lane_rx_valid, lane_healthy, lane_mask;
  logic [L*W-1:0] lane_tx_data, lane_rx_data;
  logic           out_valid, link_up;
  logic [W-1:0]   out_data;

  assign lane_rx_valid = lane_tx_valid;
  assign lane_rx_data  = lane_tx_data;

  always #5 clk = ~clk;

  lane_striper #(.W(W), .SETTLE(2)) i_lane_striper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .lane_tx_valid(lane_tx_valid), .lane_tx_data(lane_tx_data),
    .lane_rx_valid(lane_rx_valid), .lane_rx_data(lane_rx_data),
    .lane_healthy(lane_healthy), .out_valid(out_valid), .out_data(out_data),
    .link_up(link_up), .lane_mask(lane_mask)
  );

  int checks = 0, fails = 0, accepted = 0, emitted = 0;
  int lane_hits [L];
  logic [W-1:0] sbq [$];
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: pushes each accepted word into the scoreboard
  task automatic drive(int n);
    for (int k = 0; k < n; k++) begin
      bit taken;
      @(negedge clk);
      in_valid = 1'b1;
      taken = in_ready;
      if (taken) begin
        sbq.push_back(in_data);
        accepted++;
      end
      @(posedge clk);
      #1;
      if (taken) in_data = in_data + 16'd1;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_until(logic [L-1:0] m, int maxn, string req);
    for (int k = 0; k < maxn && lane_mask != m; k++) drive(1);
    chk(lane_mask == m, req, "lane set after change", lane_mask, m);
  endtask

  task automatic idle_until(logic [L-1:0] m, int maxn, string req);
    in_valid = 1'b0;
    for (int k = 0; k < maxn && lane_mask != m; k++) @(negedge clk);
    chk(lane_mask == m, req, "lane set after change", lane_mask, m);
  endtask

  // monitor: output order, lane order, switch point
  int last_lane = -1;
  logic [L-1:0] prev_mask = '0, prev_tx = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        emitted++;
        if (sbq.size() == 0) chk(0, "R5", "output with empty scoreboard", out_data, -1);
        else begin
          logic [W-1:0] e;
          e = sbq.pop_front();
          chk(out_data == e, "R5", "output word", out_data, e);
        end
      end
      if (lane_mask != prev_mask) begin
        chk(prev_tx == '0, "R6", "lane strobe before switch", prev_tx, 0);
        last_lane = -1;
      end
      if (lane_tx_valid != '0) begin
        int idx, nxt;
        idx = -1; nxt = -1;
        for (int i = 0; i < L; i++) if (lane_tx_valid[i]) idx = i;
        for (int i = L - 1; i > last_lane; i--) if (lane_mask[i]) nxt = i;
        if (nxt < 0) for (int i = L - 1; i >= 0; i--) if (lane_mask[i]) nxt = i;
        chk($countones(lane_tx_valid) == 1, "R2", "strobes per cycle", $countones(lane_tx_valid), 1);
        chk(idx == nxt, "R2", "lane order", idx, nxt);
        chk(lane_mask[idx], "R4", "strobe on inactive lane", idx, -1);
        lane_hits[idx]++;
        last_lane = idx;
      end
    end
    prev_mask = lane_mask;
    prev_tx   = lane_tx_valid;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int a0, h2;
    for (int i = 0; i < L; i++) lane_hits[i] = 0;
    lane_healthy = 4'b1111;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(link_up == 0, "R1", "link_up in reset", link_up, 0);
    chk(lane_mask == 0, "R1", "lane_mask in reset", lane_mask, 0);
    chk(in_ready == 0, "R1", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(link_up == 0, "R1", "link_up first cycle", link_up, 0);
    idle_until(4'b1111, 20, "R1");
    chk(link_up == 1, "R8", "link_up full width", link_up, 1);

    // R3 full width rate
    a0 = accepted; drive(40);
    chk(accepted - a0 == 40, "R3", "words in 40 cycles, 4 lanes", accepted - a0, 40);

    // lane 2 fails under load: R6, R3, R4
    lane_healthy = 4'b1011;
    drive_until(4'b1011, 60, "R6");
    drive(8);
    h2 = lane_hits[2];
    a0 = accepted; drive(40);
    chk(accepted - a0 == 30, "R3", "words in 40 cycles, 3 lanes", accepted - a0, 30);
    chk(lane_hits[2] == h2, "R4", "words on failed lane 2", lane_hits[2] - h2, 0);
    idle(10);
    chk(sbq.size() == 0, "R5", "words left after drain", sbq.size(), 0);

    // two lanes only: R7
    lane_healthy = 4'b0011;
    idle_until(4'b0000, 30, "R7");
    chk(link_up == 0, "R7", "link_up with two lanes", link_up, 0);
    a0 = accepted;
    for (int k = 0; k < 20; k++) begin
      drive(1);
      if (in_ready) chk(0, "R7", "in_ready while down", 1, 0);
    end
    chk(accepted == a0, "R7", "words taken while down", accepted - a0, 0);

    // restore: R8
    idle(2);
    lane_healthy = 4'b1111;
    idle_until(4'b1111, 30, "R8");
    a0 = accepted; drive(40);
    chk(accepted - a0 == 40, "R8", "full rate restored", accepted - a0, 40);

    // lowest lane fails under load, then returns: R5, R6
    lane_healthy = 4'b1110;
    drive_until(4'b1110, 60, "R6");
    a0 = accepted; drive(40);
    chk(accepted - a0 == 30, "R3", "words in 40 cycles, lanes 1..3", accepted - a0, 30);
    lane_healthy = 4'b1111;
    drive_until(4'b1111, 60, "R8");
    drive(20);
    idle(12);
    chk(sbq.size() == 0, "R5", "words left after final drain", sbq.size(), 0);
    chk(emitted == accepted, "R5", "words out vs words in", emitted, accepted);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule